// File: doc/BRIEF.md
# SDRAM Precharge Timing Scheduler

This block decides the cycle in which a precharge may go out to an SDRAM after a read or write burst, and drives the precharge command encoding together with its bank-select address bits. A memory controller reports every burst it launches: the bank, whether it is a read or a write, and whether the row should close by itself (auto-precharge). The controller can also ask for an explicit close of one bank or of all banks. The scheduler holds each request back until the timing rules allow it, and then issues it on the command pins.

Each bank has its own small state machine with four states. BK_IDLE means no row is open. BK_WAIT counts down the burst window, which is the cycles before a precharge is legal. BK_OPEN means the row is open and a precharge is allowed. BK_PRECHG counts down the row-precharge time. The transitions are as follows. IDLE goes to WAIT when a burst is accepted. WAIT goes to OPEN when the window ends and no precharge is granted. WAIT or OPEN goes to PRECHG when a precharge is granted. WAIT or OPEN returns to WAIT when a new burst reloads the window. PRECHG goes to IDLE after `TRP` cycles. A shared arbiter chooses which pending close goes out in each cycle. An all-bank close always takes priority over a single-bank close.

The command window is the same for CAS latency 2 and 3. At CAS latency CL the last read beat leaves in cycle T+CL+BL-1, and the precharge may lead it by CL-1 cycles, so the precharge falls in cycle T+BL. In this document, T is the cycle in which the burst command is presented.

Top module: `pchg_sched`

## Requirements
- R1: Whenever a precharge is issued, {pc_ras_n, pc_cas_n, pc_we_n} = 3'b010 for that cycle only. In every other cycle the three pins are 3'b111 and pc_a10 and pc_ba are 0.
- R2: After an auto-precharge read (cmd_auto_pre=1, cmd_write=0) accepted in cycle T with burst length BL, the precharge for that bank is issued in cycle T+BL at CAS latency 2 and at CAS latency 3. No precharge to that bank is issued earlier.
- R3: After an auto-precharge write accepted in cycle T, the precharge is issued in cycle T+BL-1+TWR, where TWR defaults to 2. That is TWR cycles after the last write beat in T+BL-1.
- R4: A single-bank precharge drives pc_a10=0 and pc_ba equal to the bank number.
- R5: An all-bank request (pre_req=1, pre_all=1) issues a precharge with pc_a10=1 and pc_ba=0. It goes out in the first cycle after the request in which no bank is still inside its burst window. Every bank holding an open row becomes busy in BK_PRECHG.
- R6: A single-bank request (pre_req=1, pre_all=0, pre_bank=b) to an open bank that is past its window issues in the next cycle. If bank b is still inside its window, the precharge is deferred to the end of the window.
- R7: A single-bank request to an idle bank has no effect, and no precharge is issued.
- R8: bank_busy[b] is 1 from the cycle after a burst is accepted until TRP cycles after its precharge (TRP defaults to 3). It is 0 in the cycle after that.
- R9: If cfg_cas is neither 2 nor 3, cfg_err is 1 in the next cycle and burst commands are ignored. A legal value clears cfg_err in the next cycle.
- R10: When several banks become ready to close in the same cycle, the lowest-numbered bank is issued first and the others follow in the next cycles.
- R11: A burst command to a bank in BK_PRECHG is ignored, so the bank still goes idle TRP cycles after its precharge.
- R12: After reset, the command pins are 3'b111, bank_busy is 0 and cfg_err is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A burst command is launched this cycle |
| cmd_write | input | 1 | 1 = write burst, 0 = read burst |
| cmd_bank | input | BAW | Bank of the burst |
| cmd_auto_pre | input | 1 | Close the row automatically after the burst (address bit 10 of the column command) |
| pre_req | input | 1 | Explicit precharge request |
| pre_all | input | 1 | Explicit request targets all banks |
| pre_bank | input | BAW | Target bank of a single-bank explicit request |
| cfg_cas | input | CASW | Configured CAS latency (2 or 3) |
| cfg_burst_len | input | BLW | Burst length in beats, 1 to MAX_BURST |
| pc_ras_n | output | 1 | Command pin, row strobe |
| pc_cas_n | output | 1 | Command pin, column strobe |
| pc_we_n | output | 1 | Command pin, write enable |
| pc_a10 | output | 1 | All-bank select bit of the precharge |
| pc_ba | output | BAW | Bank-select bits of the precharge |
| bank_busy | output | 2**BAW | Per-bank busy flag |
| cfg_err | output | 1 | Illegal CAS latency configured |

## Verification
The bench first runs a table of auto-precharge reads and writes. The table covers burst lengths of one and eight beats at both CAS latencies, so a window that depends on CL or that misses the TWR gap is reported. Directed cases then target the subtle behaviour. An explicit close that arrives inside the window must not cut the window short. An all-bank close must wait for a bank that is still mid-burst. Two banks that become ready together must issue lowest bank first, one per cycle. A close sent to an idle bank, a burst sent to a precharging bank, and a burst under an illegal CAS latency must all leave no trace on the pins. A design that mishandles any of these either issues the precharge too early, issues it on the wrong bank, or corrupts the busy flags that the activation logic depends on.

// File: rtl/pchg_pkg.sv
package pchg_pkg;

    typedef enum logic [1:0] {
        BK_IDLE,
        BK_WAIT,
        BK_OPEN,
        BK_PRECHG
    } bank_state_e;

    // {ras_n, cas_n, we_n}
    localparam logic [2:0] PIN_NOP = 3'b111;
    localparam logic [2:0] PIN_PRE = 3'b010;

endpackage

// File: rtl/pchg_gap_calc.sv
module pchg_gap_calc #(
    parameter int CW   = 5,
    parameter int CASW = 3,
    parameter int BLW  = 4,
    parameter int TWR  = 2
) (
    input  logic            is_write,
    input  logic [CASW-1:0] cas,
    input  logic [BLW-1:0]  blen,
    output logic [CW-1:0]   gap
);
    logic [CW-1:0] last_out;
    logic [CW-1:0] lead;
    logic [CW-1:0] rd_gap;
    logic [CW-1:0] wr_gap;

    always_comb begin
        // last read beat leaves CL+BL-1 cycles after the command
        last_out = CW'(cas) + CW'(blen) - CW'(1);
        // precharge may lead the last beat by CL-1 cycles
        lead     = CW'(cas) - CW'(1);
        rd_gap   = last_out - lead;
        // write: last beat at BL-1, then the write-recovery gap
        wr_gap   = CW'(blen) - CW'(1) + CW'(TWR);
        gap      = is_write ? wr_gap : rd_gap;
    end
endmodule

// File: rtl/pchg_bank_fsm.sv
module pchg_bank_fsm
    import pchg_pkg::*;
#(
    parameter int CW  = 5,
    parameter int TRP = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          start_ap,
    input  logic [CW-1:0] gap,
    input  logic          close_req,
    input  logic          grant,
    output logic          want,
    output logic          settled,
    output logic          holds_row,
    output logic          busy
);
    bank_state_e   state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          cls_q, cls_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BK_IDLE;
            cnt_q   <= '0;
            cls_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            cls_q   <= cls_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        cls_d   = cls_q;
        unique case (state_q)
            BK_IDLE: begin
                if (start) begin
                    state_d = BK_WAIT;
                    cnt_d   = gap - CW'(1);
                    cls_d   = start_ap;
                end
            end
            BK_WAIT: begin
                if (start) begin
                    cnt_d = gap - CW'(1);
                    cls_d = start_ap;
                end else begin
                    if (close_req) cls_d = 1'b1;
                    if (cnt_q == '0) begin
                        if (grant) begin
                            state_d = BK_PRECHG;
                            cnt_d   = CW'(TRP - 1);
                            cls_d   = 1'b0;
                        end else begin
                            state_d = BK_OPEN;
                        end
                    end else begin
                        cnt_d = cnt_q - CW'(1);
                    end
                end
            end
            BK_OPEN: begin
                if (start) begin
                    state_d = BK_WAIT;
                    cnt_d   = gap - CW'(1);
                    cls_d   = start_ap;
                end else if (grant) begin
                    state_d = BK_PRECHG;
                    cnt_d   = CW'(TRP - 1);
                    cls_d   = 1'b0;
                end else if (close_req) begin
                    cls_d = 1'b1;
                end
            end
            BK_PRECHG: begin
                cls_d = 1'b0;
                if (cnt_q == '0) state_d = BK_IDLE;
                else             cnt_d   = cnt_q - CW'(1);
            end
            default: state_d = BK_IDLE;
        endcase
    end

    always_comb begin
        holds_row = (state_q == BK_WAIT) || (state_q == BK_OPEN);
        settled   = !((state_q == BK_WAIT) && (cnt_q != '0));
        want      = cls_q && ((state_q == BK_OPEN) ||
                              ((state_q == BK_WAIT) && (cnt_q == '0)));
        busy      = (state_q != BK_IDLE);
    end

    AST_NO_EARLY_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> ((state_q == BK_OPEN) || ((state_q == BK_WAIT) && (cnt_q == '0)))); // R2
    AST_PRECHG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == BK_PRECHG) && (cnt_q != '0)) |=> (state_q == BK_PRECHG)); // R11
endmodule

// File: rtl/pchg_issue_arb.sv
module pchg_issue_arb #(
    parameter int NB  = 4,
    parameter int BAW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NB-1:0]  want,
    input  logic [NB-1:0]  settled,
    input  logic [NB-1:0]  holds_row,
    input  logic           all_pend,
    output logic           issue,
    output logic           sel_all,
    output logic [BAW-1:0] sel_ba,
    output logic [NB-1:0]  grant,
    output logic           all_done
);
    always_comb begin
        issue    = 1'b0;
        sel_all  = 1'b0;
        sel_ba   = '0;
        grant    = '0;
        all_done = 1'b0;
        if (all_pend && (&settled)) begin
            issue    = 1'b1;
            sel_all  = 1'b1;
            grant    = holds_row;
            all_done = 1'b1;
        end else if (|want) begin
            issue = 1'b1;
            for (int b = NB - 1; b >= 0; b--) begin
                if (want[b]) begin
                    sel_ba = BAW'(b);
                    grant  = NB'(1) << b;
                end
            end
        end
    end

    AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !sel_all) |-> $onehot(grant)); // R10
    AST_ALL_BANK_BA: assert property (@(posedge clk) disable iff (!rst_n)
        sel_all |-> (issue && (sel_ba == '0))); // R5
endmodule

// File: rtl/pchg_sched.sv
module pchg_sched
    import pchg_pkg::*;
#(
    parameter int BAW       = 2,
    parameter int CASW      = 3,
    parameter int MAX_BURST = 8,
    parameter int TWR       = 2,
    parameter int TRP       = 3,
    localparam int NBANK    = 1 << BAW,
    localparam int BLW      = $clog2(MAX_BURST + 1),
    localparam int CW       = $clog2(MAX_BURST + TWR + TRP + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             cmd_write,
    input  logic [BAW-1:0]   cmd_bank,
    input  logic             cmd_auto_pre,
    input  logic             pre_req,
    input  logic             pre_all,
    input  logic [BAW-1:0]   pre_bank,
    input  logic [CASW-1:0]  cfg_cas,
    input  logic [BLW-1:0]   cfg_burst_len,
    output logic             pc_ras_n,
    output logic             pc_cas_n,
    output logic             pc_we_n,
    output logic             pc_a10,
    output logic [BAW-1:0]   pc_ba,
    output logic [NBANK-1:0] bank_busy,
    output logic             cfg_err
);
    logic             cas_ok;
    logic             accept;
    logic             all_pend_q;
    logic             cfg_err_q;
    logic [CW-1:0]    gap;
    logic [NBANK-1:0] start_v, close_v, want_v, settled_v, row_v, busy_v, grant_v;
    logic             issue, sel_all, all_done;
    logic [BAW-1:0]   sel_ba;

    always_comb begin
        cas_ok = (cfg_cas == CASW'(2)) || (cfg_cas == CASW'(3));
        accept = cmd_valid && cas_ok;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            all_pend_q <= 1'b0;
            cfg_err_q  <= 1'b0;
        end else begin
            all_pend_q <= (all_pend_q && !all_done) || (pre_req && pre_all);
            cfg_err_q  <= !cas_ok;
        end
    end

    pchg_gap_calc #(.CW(CW), .CASW(CASW), .BLW(BLW), .TWR(TWR)) i_gap (
        .is_write (cmd_write),
        .cas      (cfg_cas),
        .blen     (cfg_burst_len),
        .gap      (gap)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        assign start_v[b] = accept && (cmd_bank == BAW'(b));
        assign close_v[b] = pre_req && !pre_all && (pre_bank == BAW'(b));

        pchg_bank_fsm #(.CW(CW), .TRP(TRP)) i_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .start     (start_v[b]),
            .start_ap  (cmd_auto_pre),
            .gap       (gap),
            .close_req (close_v[b]),
            .grant     (grant_v[b]),
            .want      (want_v[b]),
            .settled   (settled_v[b]),
            .holds_row (row_v[b]),
            .busy      (busy_v[b])
        );
    end

    pchg_issue_arb #(.NB(NBANK), .BAW(BAW)) i_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .want      (want_v),
        .settled   (settled_v),
        .holds_row (row_v),
        .all_pend  (all_pend_q),
        .issue     (issue),
        .sel_all   (sel_all),
        .sel_ba    (sel_ba),
        .grant     (grant_v),
        .all_done  (all_done)
    );

    always_comb begin
        {pc_ras_n, pc_cas_n, pc_we_n} = issue ? PIN_PRE : PIN_NOP;
        pc_a10    = issue && sel_all;
        pc_ba     = issue ? sel_ba : '0;
        bank_busy = busy_v;
        cfg_err   = cfg_err_q;
    end

    AST_BUSY_AFTER_PRE: assert property (@(posedge clk) disable iff (!rst_n)
        (!pc_ras_n && !pc_a10) |=> bank_busy[$past(pc_ba)]); // R8
    AST_ERR_IGNORES_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cas_ok && !bank_busy[cmd_bank]) |=> !bank_busy[$past(cmd_bank)]); // R9
    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|bank_busy) && !all_pend_q) |-> pc_ras_n); // R1
endmodule

// File: tb/test_pchg_sched.sv
module test_pchg_sched;
    localparam int TRP = 3;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cmd_valid, cmd_write, cmd_auto_pre, pre_req, pre_all;
    logic [1:0] cmd_bank, pre_bank;
    logic [2:0] cfg_cas;
    logic [3:0] cfg_burst_len;
    logic       pc_ras_n, pc_cas_n, pc_we_n, pc_a10;
    logic [1:0] pc_ba;
    logic [3:0] bank_busy;
    logic       cfg_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    pchg_sched i_pchg_sched (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_bank(cmd_bank), .cmd_auto_pre(cmd_auto_pre), .pre_req(pre_req),
        .pre_all(pre_all), .pre_bank(pre_bank), .cfg_cas(cfg_cas),
        .cfg_burst_len(cfg_burst_len), .pc_ras_n(pc_ras_n), .pc_cas_n(pc_cas_n),
        .pc_we_n(pc_we_n), .pc_a10(pc_a10), .pc_ba(pc_ba),
        .bank_busy(bank_busy), .cfg_err(cfg_err)
    );

    // table: write, bank, CAS latency, burst length, expected precharge cycle offset
    localparam int N_VEC = 8;
    localparam int V_WR [N_VEC] = '{0, 0, 0, 0, 1, 1, 1, 1};
    localparam int V_BK [N_VEC] = '{0, 1, 2, 3, 0, 1, 2, 3};
    localparam int V_CL [N_VEC] = '{2, 3, 2, 3, 2, 3, 2, 3};
    localparam int V_BL [N_VEC] = '{4, 4, 1, 8, 4, 1, 8, 2};
    localparam int V_EX [N_VEC] = '{4, 4, 1, 8, 5, 2, 9, 3};

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit is_pre();
        return {pc_ras_n, pc_cas_n, pc_we_n} == 3'b010;
    endfunction

    task automatic idle_inputs();
        cmd_valid = 0; cmd_write = 0; cmd_auto_pre = 0; cmd_bank = 0;
        pre_req = 0; pre_all = 0; pre_bank = 0;
    endtask

    task automatic burst(input bit wr, input int bk, input bit ap, input int bl);
        cmd_valid = 1; cmd_write = wr; cmd_bank = 2'(bk);
        cmd_auto_pre = ap; cfg_burst_len = 4'(bl);
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        if (!done) $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int found, fba, fa10, fenc;
        idle_inputs();
        cfg_cas = 3'd2; cfg_burst_len = 4'd4;
        rst_n = 0;
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R12 reset state
        chk({pc_ras_n, pc_cas_n, pc_we_n} == 3'b111, "R12 pins", int'({pc_ras_n, pc_cas_n, pc_we_n}), 7);
        chk(bank_busy == 4'b0, "R12 busy", int'(bank_busy), 0);
        chk(cfg_err == 1'b0, "R12 cfg_err", int'(cfg_err), 0);

        // table-driven auto-precharge bursts (R2 reads, R3 writes, R1/R4/R8)
        for (int v = 0; v < N_VEC; v++) begin
            cfg_cas = 3'(V_CL[v]);
            burst(V_WR[v] != 0, V_BK[v], 1'b1, V_BL[v]);
            found = -1; fba = 0; fa10 = 0; fenc = 0;
            for (int d = 1; d <= 20; d++) begin
                tick();
                if (d == 1) begin
                    idle_inputs();
                    chk(bank_busy[V_BK[v]], "R8 busy after command", int'(bank_busy[V_BK[v]]), 1);
                end
                if (pc_ras_n == 1'b0 && found < 0) begin
                    found = d; fba = int'(pc_ba); fa10 = int'(pc_a10);
                    fenc = int'({pc_ras_n, pc_cas_n, pc_we_n});
                end
                if (found >= 0 && d == found + TRP)
                    chk(bank_busy[V_BK[v]], "R8 busy through TRP", int'(bank_busy[V_BK[v]]), 1);
                if (found >= 0 && d == found + TRP + 1)
                    chk(!bank_busy[V_BK[v]], "R8 idle after TRP", int'(bank_busy[V_BK[v]]), 0);
            end
            if (V_WR[v] != 0) chk(found == V_EX[v], "R3 write precharge cycle", found, V_EX[v]);
            else              chk(found == V_EX[v], "R2 read precharge cycle", found, V_EX[v]);
            chk(fenc == 2, "R1 precharge encoding", fenc, 2);
            chk(fba == V_BK[v] && fa10 == 0, "R4 single bank address", fba + 4 * fa10, V_BK[v]);
        end
        cfg_cas = 3'd2;

        // R6 explicit close of an open bank issues next cycle
        burst(1'b0, 1, 1'b0, 2);
        found = -1;
        for (int d = 1; d <= 6; d++) begin
            tick();
            if (d == 1) idle_inputs();
            if (pc_ras_n == 1'b0) found = d;
        end
        chk(found < 0, "R6 no precharge without request", found, -1);
        chk(bank_busy[1], "R6 open bank stays busy", int'(bank_busy[1]), 1);
        pre_req = 1; pre_all = 0; pre_bank = 2'd1;
        tick();
        idle_inputs();
        chk(is_pre() && pc_ba == 2'd1 && !pc_a10, "R6 explicit close next cycle", int'(pc_ba), 1);
        repeat (TRP + 2) tick();

        // R6 explicit close inside the window is deferred to the window end
        burst(1'b0, 2, 1'b0, 8);
        found = -1;
        for (int d = 1; d <= 12; d++) begin
            tick();
            if (d == 1) begin pre_req = 1; pre_bank = 2'd2; cmd_valid = 0; end
            else idle_inputs();
            if (pc_ras_n == 1'b0 && found < 0) found = d;
        end
        chk(found == 8, "R6 deferred explicit close", found, 8);
        repeat (TRP + 2) tick();

        // R7 close request to an idle bank is ignored
        pre_req = 1; pre_bank = 2'd3;
        found = -1;
        for (int d = 1; d <= 5; d++) begin
            tick();
            idle_inputs();
            if (pc_ras_n == 1'b0) found = d;
        end
        chk(found < 0, "R7 idle bank close ignored", found, -1);
        chk(bank_busy == 4'b0, "R7 no bank busy", int'(bank_busy), 0);

        // R5 all-bank close of two open banks
        burst(1'b0, 0, 1'b0, 1);
        tick();
        burst(1'b0, 3, 1'b0, 1);
        tick();
        idle_inputs();
        tick(); tick();
        pre_req = 1; pre_all = 1;
        tick();
        idle_inputs();
        chk(is_pre() && pc_a10 && pc_ba == 2'd0, "R5 all-bank encoding", int'(pc_a10), 1);
        repeat (TRP) tick();
        chk(bank_busy == 4'b1001, "R5 both banks precharging", int'(bank_busy), 9);
        tick();
        chk(bank_busy == 4'b0, "R5 banks idle after TRP", int'(bank_busy), 0);

        // R5 all-bank close waits for a bank inside its window
        burst(1'b0, 1, 1'b0, 8);
        found = -1;
        for (int d = 1; d <= 12; d++) begin
            tick();
            if (d == 1) begin cmd_valid = 0; pre_req = 1; pre_all = 1; end
            else idle_inputs();
            if (pc_ras_n == 1'b0 && found < 0) begin found = d; fa10 = int'(pc_a10); end
        end
        chk(found == 8, "R5 all-bank waits for window", found, 8);
        chk(fa10 == 1, "R5 all-bank a10", fa10, 1);
        repeat (TRP + 2) tick();

        // R10 two banks ready together: lowest first
        burst(1'b0, 2, 1'b1, 2);
        tick();
        burst(1'b0, 1, 1'b1, 1);
        tick();
        idle_inputs();
        chk(is_pre() && pc_ba == 2'd1, "R10 lower bank first", int'(pc_ba), 1);
        tick();
        chk(is_pre() && pc_ba == 2'd2, "R10 higher bank next", int'(pc_ba), 2);
        repeat (TRP + 2) tick();

        // R11 burst to a precharging bank is ignored
        burst(1'b0, 0, 1'b1, 1);
        tick();
        idle_inputs();
        chk(is_pre() && pc_ba == 2'd0, "R11 setup precharge", int'(pc_ras_n), 0);
        tick();
        burst(1'b0, 0, 1'b1, 1);
        found = -1;
        for (int d = 1; d <= 8; d++) begin
            tick();
            idle_inputs();
            if (pc_ras_n == 1'b0) found = d;
            if (d == 3) chk(!bank_busy[0], "R11 bank idle on time", int'(bank_busy[0]), 0);
        end
        chk(found < 0, "R11 no second precharge", found, -1);

        // R9 illegal CAS latency
        cfg_cas = 3'd4;
        burst(1'b0, 0, 1'b1, 2);
        found = -1;
        for (int d = 1; d <= 8; d++) begin
            tick();
            idle_inputs();
            if (d == 1) begin
                chk(cfg_err, "R9 cfg_err for CL 4", int'(cfg_err), 1);
                chk(!bank_busy[0], "R9 command ignored", int'(bank_busy[0]), 0);
            end
            if (pc_ras_n == 1'b0) found = d;
        end
        chk(found < 0, "R9 no precharge under error", found, -1);
        cfg_cas = 3'd1;
        tick();
        chk(cfg_err, "R9 cfg_err for CL 1", int'(cfg_err), 1);
        cfg_cas = 3'd3;
        tick();
        chk(!cfg_err, "R9 cfg_err clears", int'(cfg_err), 0);
        chk({pc_ras_n, pc_cas_n, pc_we_n} == 3'b111 && pc_ba == 0 && !pc_a10,
            "R1 idle pins", int'({pc_ras_n, pc_cas_n, pc_we_n}), 7);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule